// File: doc/BRIEF.md
# Operand Addressing Mode Dispatcher

This control block sits between the instruction register and the microcode sequencer of a microcoded processor. It keeps operand fetching out of each instruction's own microcode. When an instruction word is loaded, the block reads how many operands the instruction carries. It then takes the operands one at a time. For each one it decodes that operand's addressing mode and drives that operand's register-select bits to the register file. It then calls a shared microcode subroutine for that mode, supplying the subroutine's start address. When the sequencer reports that the subroutine has returned, the block pulses the load strobe of the ALU input latch assigned to that operand position.

Only after the last operand has returned does the block issue the instruction field. It sends a single dispatch pulse that carries the microcode start address for execution. It then stays in an execute phase until the sequencer signals end of instruction. An operand count it cannot handle, or a reserved addressing mode, raises a one-cycle fault and returns the block to idle. The microcode ROM, the ALU and the memory bus are outside the block.

Top module: `operand_dispatcher`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block in idle. Idle means idle=1 with call_valid, dispatch_valid, latch_load and decode_fault all 0, and this holds even when the reset arrives mid-instruction.
- R2: The instruction word is 18 bits. Bits [17:16] hold the operand count, bits [15:13] and [12:10] hold operand 0's mode and register, bits [9:7] and [6:4] hold operand 1's mode and register, and bits [3:0] hold the instruction field. A count of 0 dispatches with no call, a count of 1 or 2 makes that many calls, and a count of 3 raises decode_fault with no call.
- R3: Operands are called strictly in order, operand 0 first. Each call is a call_valid pulse lasting exactly one cycle.
- R4: The call address for mode m is 0x80 + 8*m. The modes are 0 register, 1 immediate, 2 direct, 3 indexed, 4 indirect and 5 doubly indexed.
- R5: Modes 6 and 7 are reserved. Reaching an operand with a reserved mode raises decode_fault for one cycle, makes no call for it and returns to idle without dispatch.
- R6: During a call and until its return, reg_sel equals the current operand's register field, reg_sel_valid is 1, and latch_sel equals the operand index. reg_sel and latch_sel stay stable until ret_strobe arrives.
- R7: On ret_strobe while a call is outstanding, latch_load is one-hot in the same cycle, with bit k set for operand k. Otherwise latch_load is 0.
- R8: dispatch_valid is a single-cycle pulse that comes only after every operand has returned, never together with a call. dispatch_addr is 4 × the instruction field.
- R9: After dispatch the block stays busy until eoi, then returns to idle on the next edge.
- R10: ret_strobe outside an outstanding call, eoi outside the execute phase, and ir_load while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_load | input | 1 | Load ir_word as a new instruction (taken only when idle) |
| ir_word | input | 18 | Instruction word |
| idle | output | 1 | Block is waiting for an instruction |
| call_valid | output | 1 | One-cycle subroutine call request |
| call_addr | output | 8 | Start address of the mode subroutine |
| ret_strobe | input | 1 | Subroutine return from the sequencer |
| reg_sel | output | 3 | Register select of the current operand |
| reg_sel_valid | output | 1 | reg_sel is meaningful |
| latch_sel | output | 1 | Index of the current operand |
| latch_load | output | 2 | One-hot ALU input latch load strobe |
| dispatch_valid | output | 1 | One-cycle execution dispatch |
| dispatch_addr | output | 8 | Microcode start address of the instruction |
| eoi | input | 1 | End of instruction from the sequencer |
| decode_fault | output | 1 | Bad operand count or reserved mode |

## Verification
The assertions check on every cycle the properties that hold whatever instruction is loaded. These are the single-cycle width of call and dispatch pulses, the stability of reg_sel and latch_sel while a return is awaited, and a latch_load that is one-hot and tied to a return. They also check the return to idle after a fault, a reset or eoi. The bench sweeps every operand count against every pair of modes with varied sequencer latency. Only those scenarios can show that the call order and the computed addresses and register fields are right. They also show that dispatch waits for exactly the expected number of returns, and that stray strobes injected mid-instruction are ignored.

// File: rtl/opd_pkg.sv
package opd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECODE_COUNT,
    S_CALL_MODE,
    S_WAIT_RETURN,
    S_NEXT_OPERAND,
    S_DISPATCH,
    S_EXECUTE
  } opd_state_e;

  localparam int MODE_W      = 3;
  localparam int NUM_MODES   = 1 << MODE_W;
  localparam int LEGAL_MODES = 6;

  // Start address of an entry in an evenly strided microcode region.
  function automatic int strided_addr(input int base, input int index, input int stride);
    return base + index * stride;
  endfunction

  function automatic bit mode_legal(input int mode);
    return mode < LEGAL_MODES;
  endfunction

endpackage

// File: rtl/opd_field_split.sv
module opd_field_split #(
  parameter int REG_W   = 3,
  parameter int INSN_W  = 4,
  parameter int MAX_OPS = 2,
  parameter int CNT_W   = 2,
  parameter int IW      = 18
) (
  input  logic [IW-1:0]                             word_i,
  output logic [CNT_W-1:0]                          count_o,
  output logic [MAX_OPS-1:0][opd_pkg::MODE_W-1:0]   mode_o,
  output logic [MAX_OPS-1:0][REG_W-1:0]             reg_o,
  output logic [INSN_W-1:0]                         insn_o
);
  localparam int OPF_W = opd_pkg::MODE_W + REG_W;

  assign count_o = word_i[IW-1 -: CNT_W];
  assign insn_o  = word_i[INSN_W-1:0];

  // Operand 0 sits just below the count field, later operands follow downward.
  for (genvar k = 0; k < MAX_OPS; k++) begin : g_opnd
    localparam int BASE = INSN_W + (MAX_OPS - 1 - k) * OPF_W;
    assign mode_o[k] = word_i[BASE+OPF_W-1 -: opd_pkg::MODE_W];
    assign reg_o[k]  = word_i[BASE+REG_W-1 -: REG_W];
  end
endmodule

// File: rtl/opd_mode_map.sv
module opd_mode_map #(
  parameter int UA_W       = 8,
  parameter int SUB_BASE   = 128,
  parameter int SUB_STRIDE = 8
) (
  input  logic [opd_pkg::MODE_W-1:0] mode_i,
  output logic [UA_W-1:0]            start_o,
  output logic                       legal_o
);
  logic [UA_W-1:0] table_q [opd_pkg::NUM_MODES];
  logic            ok_q    [opd_pkg::NUM_MODES];

  for (genvar m = 0; m < opd_pkg::NUM_MODES; m++) begin : g_entry
    assign table_q[m] = UA_W'(opd_pkg::strided_addr(SUB_BASE, m, SUB_STRIDE));
    assign ok_q[m]    = opd_pkg::mode_legal(m);
  end

  assign start_o = table_q[mode_i];
  assign legal_o = ok_q[mode_i];
endmodule

// File: rtl/opd_exec_map.sv
module opd_exec_map #(
  parameter int INSN_W      = 4,
  parameter int UA_W        = 8,
  parameter int EXEC_BASE   = 0,
  parameter int EXEC_STRIDE = 4
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic [UA_W-1:0]   start_o
);
  assign start_o = UA_W'(opd_pkg::strided_addr(EXEC_BASE, int'(insn_i), EXEC_STRIDE));
endmodule

// File: rtl/operand_dispatcher.sv
module operand_dispatcher #(
  parameter int REG_W       = 3,
  parameter int INSN_W      = 4,
  parameter int UA_W        = 8,
  parameter int MAX_OPS     = 2,
  parameter int SUB_BASE    = 128,
  parameter int SUB_STRIDE  = 8,
  parameter int EXEC_BASE   = 0,
  parameter int EXEC_STRIDE = 4,
  localparam int CNT_W      = $clog2(MAX_OPS + 2),
  localparam int IDX_W      = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1,
  localparam int IW         = CNT_W + MAX_OPS * (opd_pkg::MODE_W + REG_W) + INSN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_load,
  input  logic [IW-1:0]     ir_word,
  output logic              idle,
  output logic              call_valid,
  output logic [UA_W-1:0]   call_addr,
  input  logic              ret_strobe,
  output logic [REG_W-1:0]  reg_sel,
  output logic              reg_sel_valid,
  output logic [IDX_W-1:0]  latch_sel,
  output logic [MAX_OPS-1:0] latch_load,
  output logic              dispatch_valid,
  output logic [UA_W-1:0]   dispatch_addr,
  input  logic              eoi,
  output logic              decode_fault
);
  import opd_pkg::*;

  opd_state_e        state_q, state_d;
  logic [IW-1:0]     ir_q;
  logic [IDX_W-1:0]  idx_q;

  logic [CNT_W-1:0]                       count_f;
  logic [MAX_OPS-1:0][MODE_W-1:0]         mode_f;
  logic [MAX_OPS-1:0][REG_W-1:0]          reg_f;
  logic [INSN_W-1:0]                      insn_f;
  logic [MODE_W-1:0]                      cur_mode;
  logic                                   cur_legal;

  // Named internal events
  logic st_idle, st_decode, st_call, st_wait, st_next, st_disp, st_exec;
  logic ev_accept, ev_bad_count, ev_no_ops, ev_call, ev_bad_mode;
  logic ev_return, ev_last, ev_eoi;

  opd_field_split #(
    .REG_W(REG_W), .INSN_W(INSN_W), .MAX_OPS(MAX_OPS), .CNT_W(CNT_W), .IW(IW)
  ) u_split (
    .word_i(ir_q), .count_o(count_f), .mode_o(mode_f), .reg_o(reg_f), .insn_o(insn_f)
  );

  assign cur_mode = mode_f[idx_q];

  opd_mode_map #(
    .UA_W(UA_W), .SUB_BASE(SUB_BASE), .SUB_STRIDE(SUB_STRIDE)
  ) u_mode (
    .mode_i(cur_mode), .start_o(call_addr), .legal_o(cur_legal)
  );

  opd_exec_map #(
    .INSN_W(INSN_W), .UA_W(UA_W), .EXEC_BASE(EXEC_BASE), .EXEC_STRIDE(EXEC_STRIDE)
  ) u_exec (
    .insn_i(insn_f), .start_o(dispatch_addr)
  );

  assign st_idle   = (state_q == S_IDLE);
  assign st_decode = (state_q == S_DECODE_COUNT);
  assign st_call   = (state_q == S_CALL_MODE);
  assign st_wait   = (state_q == S_WAIT_RETURN);
  assign st_next   = (state_q == S_NEXT_OPERAND);
  assign st_disp   = (state_q == S_DISPATCH);
  assign st_exec   = (state_q == S_EXECUTE);

  assign ev_accept    = st_idle & ir_load;
  assign ev_bad_count = st_decode & (int'(count_f) > MAX_OPS);
  assign ev_no_ops    = st_decode & (count_f == '0);
  assign ev_call      = st_call & cur_legal;
  assign ev_bad_mode  = st_call & ~cur_legal;
  assign ev_return    = st_wait & ret_strobe;
  assign ev_last      = st_next & (int'(idx_q) == int'(count_f) - 1);
  assign ev_eoi       = st_exec & eoi;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:         if (ev_accept) state_d = S_DECODE_COUNT;
      S_DECODE_COUNT: begin
        if (ev_bad_count)   state_d = S_IDLE;
        else if (ev_no_ops) state_d = S_DISPATCH;
        else                state_d = S_CALL_MODE;
      end
      S_CALL_MODE:    state_d = ev_bad_mode ? S_IDLE : S_WAIT_RETURN;
      S_WAIT_RETURN:  if (ev_return) state_d = S_NEXT_OPERAND;
      S_NEXT_OPERAND: state_d = ev_last ? S_DISPATCH : S_CALL_MODE;
      S_DISPATCH:     state_d = S_EXECUTE;
      S_EXECUTE:      if (ev_eoi) state_d = S_IDLE;
      default:        state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ir_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) ir_q <= ir_word;
      if (st_decode) idx_q <= '0;
      else if (st_next && !ev_last) idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar k = 0; k < MAX_OPS; k++) begin : g_load
    assign latch_load[k] = ev_return & (int'(idx_q) == k);
  end

  assign idle           = st_idle;
  assign call_valid     = ev_call;
  assign reg_sel_valid  = st_call | st_wait;
  assign reg_sel        = reg_f[idx_q];
  assign latch_sel      = idx_q;
  assign dispatch_valid = st_disp;
  assign decode_fault   = ev_bad_count | ev_bad_mode;

endmodule

// File: rtl/opd_checker.sv
module opd_checker #(
  parameter int REG_W   = 3,
  parameter int IDX_W   = 1,
  parameter int MAX_OPS = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               idle,
  input logic               st_wait,
  input logic               st_exec,
  input logic               call_valid,
  input logic               ret_strobe,
  input logic               eoi,
  input logic [MAX_OPS-1:0] latch_load,
  input logic [IDX_W-1:0]   latch_sel,
  input logic [REG_W-1:0]   reg_sel,
  input logic               dispatch_valid,
  input logic               decode_fault
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (idle && !call_valid && !dispatch_valid && latch_load == '0));

  a_r3_call_single: assert property (@(posedge clk) disable iff (rst)
    call_valid |=> !call_valid);

  a_r6_hold_select: assert property (@(posedge clk) disable iff (rst)
    (st_wait && !ret_strobe) |=> ($stable(latch_sel) && $stable(reg_sel)));

  a_r7_load_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(latch_load));

  a_r7_load_on_return: assert property (@(posedge clk) disable iff (rst)
    (latch_load != '0) |-> (st_wait && ret_strobe));

  a_r8_dispatch_to_exec: assert property (@(posedge clk) disable iff (rst)
    dispatch_valid |=> (st_exec && !dispatch_valid));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(dispatch_valid && call_valid));

  a_r5_fault_to_idle: assert property (@(posedge clk) disable iff (rst)
    decode_fault |=> idle);

  a_r9_exec_hold: assert property (@(posedge clk) disable iff (rst)
    (st_exec && !eoi) |=> st_exec);

  a_r9_eoi_idle: assert property (@(posedge clk) disable iff (rst)
    (st_exec && eoi) |=> idle);
endmodule

bind operand_dispatcher opd_checker #(
  .REG_W(REG_W), .IDX_W(IDX_W), .MAX_OPS(MAX_OPS)
) u_opd_checker (
  .clk(clk), .rst(rst), .idle(idle), .st_wait(st_wait), .st_exec(st_exec),
  .call_valid(call_valid), .ret_strobe(ret_strobe), .eoi(eoi),
  .latch_load(latch_load), .latch_sel(latch_sel), .reg_sel(reg_sel),
  .dispatch_valid(dispatch_valid), .decode_fault(decode_fault)
);

// File: tb/operand_dispatcher_test.sv
`timescale 1ns/1ps
module operand_dispatcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_load = 1'b0;
  logic [17:0] ir_word = '0;
  logic        ret_strobe = 1'b0;
  logic        eoi = 1'b0;
  logic        idle, call_valid, reg_sel_valid, dispatch_valid, decode_fault;
  logic [7:0]  call_addr, dispatch_addr;
  logic [2:0]  reg_sel;
  logic [0:0]  latch_sel;
  logic [1:0]  latch_load;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  operand_dispatcher uut (
    .clk(clk), .rst(rst), .ir_load(ir_load), .ir_word(ir_word), .idle(idle),
    .call_valid(call_valid), .call_addr(call_addr), .ret_strobe(ret_strobe),
    .reg_sel(reg_sel), .reg_sel_valid(reg_sel_valid), .latch_sel(latch_sel),
    .latch_load(latch_load), .dispatch_valid(dispatch_valid),
    .dispatch_addr(dispatch_addr), .eoi(eoi), .decode_fault(decode_fault)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // One instruction, driven and observed cycle by cycle at falling edges.
  task automatic run_one(input int cnt, input int m0, input int r0, input int m1,
                         input int r1, input int f, input int lat0, input int lat1);
    int  modes[2], regs[2], lats[2];
    int  exp_calls, ncall, cd, phase, ex_cnt;
    bit  exp_fault, pending, saw_fault, saw_disp, done;
    modes[0] = m0; modes[1] = m1; regs[0] = r0; regs[1] = r1;
    lats[0] = lat0; lats[1] = lat1;
    exp_fault = 0; exp_calls = 0;
    if (cnt == 3) exp_fault = 1;
    else begin
      for (int k = 0; k < cnt; k++) begin
        if (!exp_fault) begin
          if (modes[k] >= 6) exp_fault = 1;
          else exp_calls++;
        end
      end
    end
    ir_word = {2'(cnt), 3'(m0), 3'(r0), 3'(m1), 3'(r1), 4'(f)};
    ir_load = 1'b1;
    @(negedge clk);
    ir_load = 1'b0;
    ncall = 0; cd = 0; phase = 0; ex_cnt = 0;
    pending = 0; saw_fault = 0; saw_disp = 0; done = 0;
    for (int cyc = 0; cyc < 80 && !done; cyc++) begin
      ret_strobe = 1'b0; eoi = 1'b0; ir_load = 1'b0;
      if (phase == 2) begin
        chk(idle == 1'b1, "R9 idle after end", idle, 1);
        chk(call_valid == 1'b0, "R10 no call once idle", call_valid, 0);
        done = 1;
      end else if (phase == 1) begin
        if (ex_cnt > 0) begin
          ret_strobe = 1'b1; ir_load = 1'b1; #1;
          chk(latch_load == 2'b00, "R10 stray return in execute", latch_load, 0);
          chk(idle == 1'b0, "R9 busy during execute", idle, 0);
          ex_cnt--;
        end else begin
          eoi = 1'b1;
          phase = 2;
        end
      end else begin
        if (decode_fault) begin
          saw_fault = 1;
          chk(exp_fault, "R5 fault expected", 1, exp_fault);
          chk(ncall == exp_calls, "R2 calls before fault", ncall, exp_calls);
          chk(call_valid == 1'b0, "R5 no call on fault", call_valid, 0);
          phase = 2;
        end
        if (call_valid) begin
          chk(ncall < exp_calls, "R3 call count", ncall, exp_calls);
          chk(call_addr == 8'(128 + 8 * modes[ncall]), "R4 call address",
              call_addr, 128 + 8 * modes[ncall]);
          chk(reg_sel == 3'(regs[ncall]) && reg_sel_valid, "R6 register select",
              reg_sel, regs[ncall]);
          chk(latch_sel == 1'(ncall), "R6 latch select", latch_sel, ncall);
          pending = 1; cd = lats[ncall];
        end else if (pending) begin
          if (cd == 0) begin
            ret_strobe = 1'b1; #1;
            chk(latch_load == 2'(1 << ncall), "R7 latch load", latch_load, 1 << ncall);
            pending = 0; ncall++;
          end else begin
            cd--;
            eoi = 1'b1; ir_load = 1'b1; #1;
            chk(latch_load == 2'b00, "R10 no load while waiting", latch_load, 0);
          end
        end
        if (dispatch_valid) begin
          saw_disp = 1;
          chk(!exp_fault && ncall == exp_calls, "R8 dispatch after last return",
              ncall, exp_calls);
          chk(dispatch_addr == 8'(4 * f), "R8 dispatch address", dispatch_addr, 4 * f);
          phase = 1; ex_cnt = 2;
        end
      end
      @(negedge clk);
    end
    ret_strobe = 1'b0; eoi = 1'b0; ir_load = 1'b0;
    chk(done, "R9 instruction completed", done, 1);
    chk(saw_fault == exp_fault, "R2 fault outcome", saw_fault, exp_fault);
    chk(saw_disp == !exp_fault, "R2 dispatch outcome", saw_disp, !exp_fault);
    chk(ncall == exp_calls, "R3 total calls", ncall, exp_calls);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1 idle after reset", idle, 1);
    chk(call_valid == 1'b0 && dispatch_valid == 1'b0, "R1 no pulses after reset",
        call_valid | dispatch_valid, 0);
    chk(latch_load == 2'b00 && decode_fault == 1'b0, "R1 no load or fault after reset",
        latch_load, 0);

    // R1 reset in the middle of an operand wait
    ir_word = {2'd2, 3'd1, 3'd2, 3'd3, 3'd4, 4'd5};
    ir_load = 1'b1;
    @(negedge clk); ir_load = 1'b0;
    repeat (3) @(negedge clk);
    chk(idle == 1'b0, "R1 busy before reset", idle, 0);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(idle == 1'b1, "R1 idle after mid reset", idle, 1);
    ret_strobe = 1'b1; #1;
    chk(latch_load == 2'b00, "R10 return ignored when idle", latch_load, 0);
    @(negedge clk); ret_strobe = 1'b0;
    chk(idle == 1'b1 && call_valid == 1'b0, "R10 idle after stray return", idle, 1);

    // Sweep every count against every mode pair
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          run_one(c, a, (a + c) % 8, b, (b * 3 + 1) % 8, (a * 8 + b + c) % 16,
                  (a + b) % 4, (b + c) % 3);

    summary();
    $finish;
  end
endmodule